// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between the MAC transmit-enable and the line driver of a 10 Mb/s Ethernet port. It stops a transmitter that stays on too long. While the MAC request stays high without a break, a trip timer counts strobes from a slow time base. When that timer reaches its limit, the block enters the jabber state. In that state it cuts the line enable, signals a collision back to the MAC, turns on a jabber LED and, in twisted-pair operation, tells the loopback path to stop copying transmit data to the receiver.

A second, longer release timer controls the way out. It counts strobes only while the MAC request is idle. Any request during the idle wait sends that timer back to zero. Both limits are parameters in strobe ticks. The defaults suit a 1 ms strobe (32 to trip, 256 to release), and a bench can use short values instead.

Top module: `tx_jabber_guard`

## Requirements
- R1: If `mac_tx_en` is high on every cycle from before the first counted `tick` through the TRIP_TICKS-th `tick`, `jabber` is 1 from the next cycle on.
- R2: A low cycle on `mac_tx_en` outside the jabber state clears the trip count, so a request dropped after TRIP_TICKS-1 ticks never raises `jabber`.
- R3: While `jabber` is 1, `line_tx_en` is 0 whatever `mac_tx_en` does.
- R4: `col_force` is 1 exactly on the cycles where `jabber` is 1.
- R5: `loopback_inhibit` is 1 exactly when `jabber` is 1 and `tp_mode` is 1; when `tp_mode` is 0 it stays 0.
- R6: In the jabber state, once RELEASE_TICKS ticks have been counted with `mac_tx_en` low on every cycle since the count began, `jabber` returns to 0 on the next cycle.
- R7: A cycle with `mac_tx_en` high during the jabber state restarts the release count from zero, and this includes the cycle of the final tick.
- R8: `jabber_led` is 1 exactly when `jabber` is 1.
- R9: While `rst_n` is 0 and on the first cycle after it, `jabber` is 0 and both timers are clear.
- R10: Outside the jabber state, `line_tx_en` equals `mac_tx_en` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe (1 ms nominal) |
| mac_tx_en | input | 1 | Transmit request from the MAC |
| tp_mode | input | 1 | 1 when the port runs on twisted pair |
| line_tx_en | output | 1 | Gated transmit enable to the line |
| jabber | output | 1 | Jabber state flag |
| col_force | output | 1 | Forced collision indication to the MAC |
| loopback_inhibit | output | 1 | Disables automatic transmit-to-receive loopback |
| jabber_led | output | 1 | Jabber LED drive |

## Verification
Two events can land on the same clock edge and pull in opposite directions. The first is the strobe that would complete a timer. The second is a change of `mac_tx_en` that would clear that same timer. At the trip edge, a request that drops in the cycle of the final tick must not cause a trip. At the release edge, a request that rises in the cycle of the final tick must keep the block jabbing. The bench forces both cases with directed sequences and also meets them often in random bursts with dense strobes. It judges every cycle against a bench model built from the requirements.

// File: rtl/jab_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the transmit jabber watchdog.
// Assumes: nothing beyond a single clock domain.
package jab_pkg;
    typedef enum logic {
        JS_NORMAL = 1'b0,
        JS_JABBER = 1'b1
    } jab_state_t;
endpackage

// File: rtl/jab_tick_counter.sv
`timescale 1ns/1ps
// Module: jab_tick_counter
// Counts strobe ticks while `run` stays high and clears on any cycle
// where `run` is low. It raises `expire` in the cycle that holds the
// LIMIT-th tick, then wraps back to zero.
// Assumes: LIMIT >= 1 and `tick` is a one-cycle strobe.
module jab_tick_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Purpose: flag the count value that the final tick completes.
    always_comb begin
        at_last = (cnt_q == LAST);
        expire  = run && tick && at_last;
    end

    // Purpose: step the count on ticks while running, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (at_last) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jab_state_ctl.sv
`timescale 1ns/1ps
// Module: jab_state_ctl
// Holds the two-state jabber register. A trip expiry moves it into the
// jabber state and a release expiry moves it out.
// Assumes: trip_expire fires only in the normal state and rel_expire only
// in the jabber state. The top gates the counter run inputs to make this so.
module jab_state_ctl
    import jab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_expire,
    input  logic rel_expire,
    output logic jab_on
);
    jab_state_t st_q, st_d;

    // Purpose: choose the next state from the timer expiries.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            JS_NORMAL: if (trip_expire) st_d = JS_JABBER;
            JS_JABBER: if (rel_expire)  st_d = JS_NORMAL;
            default:   st_d = JS_NORMAL;
        endcase
    end

    // Purpose: register the state and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= JS_NORMAL;
        else        st_q <= st_d;
    end

    assign jab_on = (st_q == JS_JABBER);
endmodule

// File: rtl/jab_out_drv.sv
`timescale 1ns/1ps
// Module: jab_out_drv
// Derives the line enable and the indications from the jabber state.
// It is purely combinational, so the line enable follows the MAC request
// in the same cycle.
// Assumes: jab_on comes straight from a register.
module jab_out_drv (
    input  logic jab_on,
    input  logic mac_tx_en,
    input  logic tp_mode,
    output logic line_tx_en,
    output logic col_force,
    output logic loopback_inhibit,
    output logic jabber_led
);
    // Purpose: block the transmitter and raise the indications while jabbing.
    always_comb begin
        line_tx_en       = mac_tx_en && !jab_on;
        col_force        = jab_on;
        loopback_inhibit = jab_on && tp_mode;
        jabber_led       = jab_on;
    end
endmodule

// File: rtl/tx_jabber_guard.sv
`timescale 1ns/1ps
// Module: tx_jabber_guard (top)
// Transmit jabber watchdog. A trip timer runs while the MAC request is
// held outside the jabber state. A release timer runs while the request
// is idle inside the jabber state.
// Assumes: `tick` is a one-cycle strobe from a slow time base, and the
// limits are given in ticks.
module tx_jabber_guard #(
    parameter int TRIP_TICKS    = 32,
    parameter int RELEASE_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mac_tx_en,
    input  logic tp_mode,
    output logic line_tx_en,
    output logic jabber,
    output logic col_force,
    output logic loopback_inhibit,
    output logic jabber_led
);
    logic jab_on;
    logic trip_run, rel_run;
    logic trip_expire, rel_expire;

    // Purpose: run each timer only in its own state and input condition.
    always_comb begin
        trip_run = mac_tx_en && !jab_on;
        rel_run  = !mac_tx_en && jab_on;
    end

    jab_tick_counter #(.LIMIT(TRIP_TICKS)) u_trip (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (trip_run),
        .tick   (tick),
        .expire (trip_expire)
    );

    jab_tick_counter #(.LIMIT(RELEASE_TICKS)) u_release (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rel_run),
        .tick   (tick),
        .expire (rel_expire)
    );

    jab_state_ctl u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_expire (trip_expire),
        .rel_expire  (rel_expire),
        .jab_on      (jab_on)
    );

    jab_out_drv u_out (
        .jab_on           (jab_on),
        .mac_tx_en        (mac_tx_en),
        .tp_mode          (tp_mode),
        .line_tx_en       (line_tx_en),
        .col_force        (col_force),
        .loopback_inhibit (loopback_inhibit),
        .jabber_led       (jabber_led)
    );

    assign jabber = jab_on;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
`timescale 1ns/1ps
// Module: tx_jabber_guard_chk
// Property checker for tx_jabber_guard. It is bound to every instance of
// the top module.
// Assumes: synchronous active-low reset.
module tx_jabber_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic mac_tx_en,
    input logic tp_mode,
    input logic line_tx_en,
    input logic jabber,
    input logic col_force,
    input logic loopback_inhibit,
    input logic jabber_led
);
    // R1: jabber can only start after a tick with the request held high
    p_trip_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber) |-> ($past(mac_tx_en) && $past(tick)));

    // R3: the line stays off while jabbing
    p_line_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> !line_tx_en);

    // R4: the collision indication is on while jabbing
    p_col_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> col_force);

    // R5: loopback is inhibited only while jabbing in twisted-pair mode
    p_loop_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_inhibit |-> (jabber && tp_mode));

    // R6: jabber can only end after an idle tick
    p_release_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber) |-> (!$past(mac_tx_en) && $past(tick)));

    // R8: the LED agrees with the collision indication
    p_led_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_led == col_force);

    // R9: reset leaves the block out of the jabber state
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> !jabber);

    // R10: outside jabber the line enable follows the request
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !jabber |-> (line_tx_en == mac_tx_en));
endmodule

bind tx_jabber_guard tx_jabber_guard_chk u_chk (.*);

// File: tb/tb_tx_jabber_guard.sv
`timescale 1ns/1ps
module tb_tx_jabber_guard;
    localparam int TRIP = 5;
    localparam int REL  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, mac_tx_en = 1'b0, tp_mode = 1'b1;
    logic line_tx_en, jabber, col_force, loopback_inhibit, jabber_led;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state, built from the requirements
    bit m_jab;
    int m_tc, m_rc;

    always #2.5 clk = ~clk;

    tx_jabber_guard #(.TRIP_TICKS(TRIP), .RELEASE_TICKS(REL)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mac_tx_en(mac_tx_en),
        .tp_mode(tp_mode), .line_tx_en(line_tx_en), .jabber(jabber),
        .col_force(col_force), .loopback_inhibit(loopback_inhibit),
        .jabber_led(jabber_led));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_line(input bit tx, input bit jab);
        return tx && !jab;
    endfunction

    function automatic logic exp_loop(input bit jab, input bit tp);
        return jab && tp;
    endfunction

    task automatic model_step(input bit rst, input bit tx, input bit tk);
        if (!rst) begin
            m_jab = 0; m_tc = 0; m_rc = 0;
        end else if (!m_jab) begin
            if (!tx) m_tc = 0;
            else if (tk) begin
                if (m_tc == TRIP - 1) begin m_jab = 1; m_tc = 0; m_rc = 0; end
                else m_tc++;
            end
        end else begin
            if (tx) m_rc = 0;
            else if (tk) begin
                if (m_rc == REL - 1) begin m_jab = 0; m_rc = 0; m_tc = 0; end
                else m_rc++;
            end
        end
    endtask

    task automatic step(input bit tx, input bit tk, input bit tp);
        @(negedge clk);
        mac_tx_en = tx; tick = tk; tp_mode = tp;
        #1;
        chk("R1_R6_R7 jabber", jabber, m_jab);
        chk(m_jab ? "R3 line" : "R10 line", line_tx_en, exp_line(tx, m_jab));
        chk("R4 col", col_force, m_jab);
        chk("R5 loop", loopback_inhibit, exp_loop(m_jab, tp));
        chk("R8 led", jabber_led, m_jab);
        @(posedge clk);
        model_step(rst_n, tx, tk);
    endtask

    task automatic run_ticks(input bit tx, input int n, input bit tp);
        for (int i = 0; i < n; i++) begin
            step(tx, 1'b0, tp);
            step(tx, 1'b1, tp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mac_tx_en = 1'b1; tick = 1'b1;
        @(posedge clk); model_step(1'b0, 1'b1, 1'b1);
        @(negedge clk); #1;
        chk("R9 jabber in reset", jabber, 1'b0);
        @(posedge clk); model_step(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1; mac_tx_en = 1'b0; tick = 1'b0;
        #1;
        chk("R9 jabber after reset", jabber, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        bit burst;
        seed = 32'd4242;
        void'($urandom(seed));
        m_jab = 0; m_tc = 0; m_rc = 0;
        do_reset();

        // R2: TRIP-1 ticks, then drop, then TRIP-1 again: no jabber
        run_ticks(1'b1, TRIP - 1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        run_ticks(1'b1, TRIP - 1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R2 no trip after cleared count", jabber, 1'b0);

        // R2: drop in the cycle of the final tick must not trip
        run_ticks(1'b1, TRIP - 1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R2 drop on final tick", jabber, 1'b0);

        // R1: exactly TRIP ticks held trips on the next cycle
        run_ticks(1'b1, TRIP, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        chk("R1 trip at limit", jabber, 1'b1);
        chk("R3 line cut", line_tx_en, 1'b0);

        // R7: request on the final release tick restarts the count
        run_ticks(1'b0, REL - 1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R7 still jabbing after late request", jabber, 1'b1);
        chk("R5 no inhibit when not twisted pair", loopback_inhibit, 1'b0);
        run_ticks(1'b0, REL - 1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 count restarted", jabber, 1'b1);

        // R6: the last needed idle tick releases
        run_ticks(1'b0, 1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R6 released", jabber, 1'b0);

        // random bursts with dense ticks
        burst = 1'b0;
        for (int c = 0; c < 6000; c++) begin
            bit tx, tk, tp;
            if (c % 150 == 0) burst = $urandom_range(0, 1);
            tx = burst ? ($urandom_range(0, 99) < 97) : ($urandom_range(0, 99) < 4);
            tk = ($urandom_range(0, 3) == 0);
            tp = ($urandom_range(0, 7) != 0);
            step(tx, tk, tp);
        end

        // R9: reset from inside jabber
        run_ticks(1'b1, TRIP + 1, 1'b1);
        do_reset();
        step(1'b1, 1'b0, 1'b1);
        chk("R9 line released after reset", line_tx_en, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule